// File: doc/BRIEF.md
# External Sample Memory Fetch Interface

This block sits between a sample playback engine and an external read-only sample memory of up to 128 Mbit. The engine hands it a byte address with a valid/ready handshake. The block puts a 23-bit word address on the memory address pins and holds the active-low output enable low for a fixed number of system clocks. It then captures the memory data into a 16-bit holding register and raises a one-cycle data-valid pulse.

A static width strap selects the memory organisation. With the strap high, the memory is 16 bits wide and all sixteen data pins carry data. With the strap low, the memory is 8 bits wide: the pad of data bit 15 becomes an extra low-order address output that selects the byte, and data bits 14 to 8 are ignored.

A bus-release input lets another master own the memory. While it is high, the block stops driving every address and enable output and accepts no new request. A fetch that is in progress pauses and resumes when the bus comes back. Output drive is given as separate enable signals, and the pad ring turns them into high impedance.

Top module: `extmem_fetch`

## Requirements
- R1: After a synchronous active-low reset: rsp_valid is 0, rsp_data is 0, mem_oe_n is 1, mem_addr is 0, and req_ready is 1 while bus_release is 0.
- R2: The fetch is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle, mem_addr equals req_addr[23:1] and stays stable until the next fetch is accepted.
- R3: mem_lsb equals req_addr[0] of the accepted fetch. mem_lsb_drive is 1 exactly when wide_strap is 0 (byte mode) and bus_release is 0; in word mode (wide_strap 1) the pin is never driven.
- R4: Each fetch holds mem_oe_n at 0 with mem_addr_drive at 1 for exactly STROBE_CYCLES cycles, counted from the cycle after acceptance.
- R5: rsp_valid is 1 for exactly one cycle, the cycle after the last driven strobe cycle, and mem_oe_n returns to 1 in that same cycle. In word mode rsp_data holds mem_dq[15:0] as sampled in the last strobe cycle, and it holds that value until the next capture.
- R6: In byte mode (wide_strap 0 at acceptance), rsp_data is {8'h00, mem_dq[7:0]}. mem_dq[15:8] has no effect.
- R7: While bus_release is 1, mem_addr_drive and mem_lsb_drive are 0. When bus_release is 0, mem_addr_drive is 1.
- R8: While bus_release is 1, req_ready is 0 and no request is accepted. A request held across the release is accepted on the first edge where bus_release is 0.
- R9: If bus_release rises during a strobe, the strobe count pauses and resumes when release falls. Data is captured only after STROBE_CYCLES driven strobe cycles.
- R10: req_ready is 0 from the cycle after acceptance until rsp_valid is 1. Requests in that window are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 24 | Byte address of the fetch |
| req_ready | output | 1 | Block can accept a fetch this cycle |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data updated |
| rsp_data | output | 16 | Holding register with fetched data |
| wide_strap | input | 1 | 1 = 16-bit memory, 0 = 8-bit memory |
| bus_release | input | 1 | 1 = another master owns the memory bus |
| mem_addr | output | 23 | Word address to memory |
| mem_addr_drive | output | 1 | Drive enable for mem_addr and mem_oe_n |
| mem_lsb | output | 1 | Byte-select address bit on the data-15 pad |
| mem_lsb_drive | output | 1 | Drive enable for mem_lsb |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_dq | input | 16 | Memory data pins |

## Verification
mem_addr and mem_lsb change in the cycle after the accepting edge. mem_oe_n falls in that same cycle and stays low for STROBE_CYCLES driven cycles. rsp_valid and the new rsp_data follow one cycle after the last of those cycles. req_ready, mem_addr_drive and mem_lsb_drive follow bus_release and wide_strap in the same cycle, with no register in the path.

The bench reference model advances on each rising edge using only the bench's own inputs. Every output is compared with it at the falling edge that follows, so each registered result is checked in the first cycle it is due, and each combinational one in the cycle its input changed. The memory data changes every cycle, so a capture taken one cycle early or late gives the wrong word.

// File: rtl/extmem_pkg.sv
// Package: shared types for the external memory fetch interface.
// Assumes: nothing beyond IEEE 1800-2017.
package extmem_pkg;

    // Fetch sequencer state
    typedef enum logic {
        FS_IDLE   = 1'b0,
        FS_STROBE = 1'b1
    } fetch_state_e;

    // Memory organisation, encoded as the width strap level
    typedef enum logic {
        ORG_BYTE = 1'b0,
        ORG_WORD = 1'b1
    } mem_org_e;

endpackage

// File: rtl/extmem_strobe_ctrl.sv
// Module: extmem_strobe_ctrl
// Sequences a fetch: accepts a request when idle and the bus is owned,
// holds the strobe for STROBE_CYCLES owned cycles, then asks for capture.
// Assumes: STROBE_CYCLES >= 1; the count pauses while the bus is released.
module extmem_strobe_ctrl
    import extmem_pkg::*;
#(
    parameter int STROBE_CYCLES = 3,
    localparam int CNT_W = (STROBE_CYCLES < 2) ? 1 : $clog2(STROBE_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_release,
    output logic req_ready,
    output logic accept,
    output logic strobe_on,
    output logic capture
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYCLES - 1);

    fetch_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;

    // Handshake and capture decode
    always_comb begin
        req_ready = (state_q == FS_IDLE) && !bus_release;
        accept    = req_ready && req_valid;
        strobe_on = (state_q == FS_STROBE);
        capture   = strobe_on && !bus_release && (cnt_q == LAST_CNT);
    end

    // State and owned-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    cnt_q <= '0;
                    if (accept) state_q <= FS_STROBE;
                end
                FS_STROBE: begin
                    if (capture) begin
                        state_q <= FS_IDLE;
                        cnt_q   <= '0;
                    end else if (!bus_release) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/extmem_addr_path.sv
// Module: extmem_addr_path
// Registers the accepted byte address and splits it into the word address
// and the byte-select bit. Produces the pad drive enables and the latched
// memory organisation.
// Assumes: wide_strap is static during operation; release gates drive only.
module extmem_addr_path
    import extmem_pkg::*;
#(
    parameter int MEM_AW = 23,
    localparam int BYTE_AW = MEM_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [BYTE_AW-1:0] req_addr,
    input  logic               wide_strap,
    input  logic               bus_release,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_lsb,
    output logic               mem_addr_drive,
    output logic               mem_lsb_drive,
    output mem_org_e           org_q
);

    logic [BYTE_AW-1:0] addr_q;

    // Address and organisation capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            org_q  <= ORG_WORD;
        end else if (accept) begin
            addr_q <= req_addr;
            org_q  <= mem_org_e'(wide_strap);
        end
    end

    // Split the byte address and derive the pad drive enables
    always_comb begin
        mem_addr       = addr_q[BYTE_AW-1:1];
        mem_lsb        = addr_q[0];
        mem_addr_drive = !bus_release;
        mem_lsb_drive  = !bus_release && (mem_org_e'(wide_strap) == ORG_BYTE);
    end

endmodule

// File: rtl/extmem_data_capture.sv
// Module: extmem_data_capture
// Holding register for fetched data. In byte organisation only the low lane
// is kept and the upper lane reads as zero. Pulses valid for one cycle.
// Assumes: capture is a single-cycle strobe from the sequencer.
module extmem_data_capture
    import extmem_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  mem_org_e          org_q,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    logic [DATA_W-1:0] lane_fmt;

    // Select the lanes according to the latched organisation
    always_comb begin
        if (org_q == ORG_BYTE) lane_fmt = {{(DATA_W-HALF_W){1'b0}}, mem_dq[HALF_W-1:0]};
        else                   lane_fmt = mem_dq;
    end

    // Holding register and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_data <= lane_fmt;
        end
    end

endmodule

// File: rtl/extmem_fetch.sv
// Module: extmem_fetch (top)
// Read-only fetch interface to an external sample memory in byte or word
// organisation, with bus release for a second master.
// Assumes: pad ring turns the *_drive enables into high impedance and muxes
// mem_lsb onto the data-15 pad in byte organisation.
module extmem_fetch
    import extmem_pkg::*;
#(
    parameter int MEM_AW        = 23,
    parameter int DATA_W        = 16,
    parameter int STROBE_CYCLES = 3,
    localparam int BYTE_AW = MEM_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BYTE_AW-1:0] req_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    input  logic               wide_strap,
    input  logic               bus_release,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_addr_drive,
    output logic               mem_lsb,
    output logic               mem_lsb_drive,
    output logic               mem_oe_n,
    input  logic [DATA_W-1:0]  mem_dq
);

    logic     accept;
    logic     strobe_on;
    logic     capture;
    mem_org_e org_q;

    extmem_strobe_ctrl #(.STROBE_CYCLES(STROBE_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bus_release(bus_release),
        .req_ready  (req_ready),
        .accept     (accept),
        .strobe_on  (strobe_on),
        .capture    (capture)
    );

    extmem_addr_path #(.MEM_AW(MEM_AW)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .req_addr      (req_addr),
        .wide_strap    (wide_strap),
        .bus_release   (bus_release),
        .mem_addr      (mem_addr),
        .mem_lsb       (mem_lsb),
        .mem_addr_drive(mem_addr_drive),
        .mem_lsb_drive (mem_lsb_drive),
        .org_q         (org_q)
    );

    extmem_data_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .org_q    (org_q),
        .mem_dq   (mem_dq),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    // Output enable follows the strobe phase
    always_comb mem_oe_n = !strobe_on;

endmodule

// File: rtl/extmem_fetch_chk.sv
// Module: extmem_fetch_chk
// Property checker for extmem_fetch, attached by bind below.
module extmem_fetch_chk #(
    parameter int MEM_AW        = 23,
    parameter int STROBE_CYCLES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              wide_strap,
    input logic              bus_release,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_addr_drive,
    input logic              mem_lsb_drive,
    input logic              mem_oe_n
);

    int unsigned owned_low;

    // Count driven strobe cycles since the last response
    always_ff @(posedge clk) begin
        if (!rst_n)                          owned_low <= 0;
        else if (rsp_valid)                  owned_low <= 0;
        else if (!mem_oe_n && mem_addr_drive) owned_low <= owned_low + 1;
    end

    a_r7_release_floats: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |-> (!mem_addr_drive && !mem_lsb_drive));

    a_r3_word_lsb_float: assert property (@(posedge clk) disable iff (!rst_n)
        wide_strap |-> !mem_lsb_drive);

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !req_ready);

    a_r8_release_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |-> !req_ready);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    a_r4_strobe_length: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (owned_low == STROBE_CYCLES));

endmodule

bind extmem_fetch extmem_fetch_chk #(
    .MEM_AW       (MEM_AW),
    .STROBE_CYCLES(STROBE_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .wide_strap    (wide_strap),
    .bus_release   (bus_release),
    .mem_addr      (mem_addr),
    .mem_addr_drive(mem_addr_drive),
    .mem_lsb_drive (mem_lsb_drive),
    .mem_oe_n      (mem_oe_n)
);

// File: tb/extmem_fetch_tb.sv
// Bench for extmem_fetch: a behavioural reference model is advanced on
// each rising edge and every output is compared on each falling edge.
module extmem_fetch_tb;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        wide_strap = 1'b1;
    logic        bus_release = 1'b0;
    logic [22:0] mem_addr;
    logic        mem_addr_drive;
    logic        mem_lsb;
    logic        mem_lsb_drive;
    logic        mem_oe_n;
    logic [15:0] mem_dq = 16'h0000;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit started = 0;

    // Reference model state
    bit          m_busy = 0;
    int          m_cnt = 0;
    logic [23:0] m_addr = '0;
    bit          m_byte = 0;
    bit          m_vld = 0;
    logic [15:0] m_data = '0;

    extmem_fetch #(.STROBE_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wide_strap(wide_strap), .bus_release(bus_release), .mem_addr(mem_addr),
        .mem_addr_drive(mem_addr_drive), .mem_lsb(mem_lsb),
        .mem_lsb_drive(mem_lsb_drive), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Reference model: behaviour from the requirements
    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_addr = '0; m_byte = 0; m_vld = 0; m_data = '0;
        end else begin
            m_vld = 0;
            if (!m_busy) begin
                if (req_valid && !bus_release) begin
                    m_busy = 1; m_cnt = 0; m_addr = req_addr; m_byte = !wide_strap;
                end
            end else if (!bus_release) begin
                m_cnt++;
                if (m_cnt == N) begin
                    m_busy = 0;
                    m_vld = 1;
                    m_data = m_byte ? {8'h00, mem_dq[7:0]} : mem_dq;
                end
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R8 R10 req_ready", req_ready, !m_busy && !bus_release);
            chk("R4 R9 mem_oe_n", mem_oe_n, !m_busy);
            chk("R7 mem_addr_drive", mem_addr_drive, !bus_release);
            chk("R3 mem_lsb_drive", mem_lsb_drive, !bus_release && !wide_strap);
            chk("R2 mem_addr", mem_addr, m_addr[23:1]);
            chk("R3 mem_lsb", mem_lsb, m_addr[0]);
            chk("R5 rsp_valid", rsp_valid, m_vld);
            chk("R5 R6 rsp_data", rsp_data, m_data);
        end
    end

    // Data pins change every cycle, upper lane deliberately noisy
    always @(negedge clk) begin
        #1 mem_dq <= {8'(cyc * 37) ^ 8'hC3, 8'(cyc * 11 + 5)};
    end

    // Watchdog
    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic tick();
        @(negedge clk); #2;
    endtask

    // Issue one fetch, hold req_valid until accepted, wait for the response
    task automatic fetch(input logic [23:0] a, input bit wide);
        wide_strap = wide;
        req_addr = a;
        req_valid = 1'b1;
        do tick(); while (!m_busy);
        req_valid = 1'b0;
        while (m_busy) tick();
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_data", rsp_data, 0);
        chk("R1 mem_oe_n", mem_oe_n, 1);
        chk("R1 mem_addr", mem_addr, 0);
        chk("R1 req_ready", req_ready, 1);

        // Word organisation (R2, R4, R5)
        fetch(24'h000002, 1);
        fetch(24'hFFFFFE, 1);
        fetch(24'h123457, 1);
        // Byte organisation (R3, R6)
        fetch(24'h000001, 0);
        fetch(24'hABCDE0, 0);
        fetch(24'hFFFFFF, 0);

        // R8: request held across a release
        bus_release = 1'b1;
        req_addr = 24'h5A5A5B;
        wide_strap = 1'b0;
        req_valid = 1'b1;
        repeat (5) tick();
        chk("R8 not accepted while released", mem_oe_n, 1);
        bus_release = 1'b0;
        do tick(); while (!m_busy);
        req_valid = 1'b0;
        while (m_busy) tick();
        tick();

        // R9: release in the middle of a strobe
        wide_strap = 1'b1;
        req_addr = 24'h3C3C3C;
        req_valid = 1'b1;
        do tick(); while (!m_busy);
        req_valid = 1'b0;
        tick();
        bus_release = 1'b1;
        repeat (3) tick();
        chk("R9 strobe paused, no capture", rsp_valid, 0);
        bus_release = 1'b0;
        while (m_busy) tick();
        tick();

        // R10: request kept high back to back
        wide_strap = 1'b1;
        req_addr = 24'h000100;
        req_valid = 1'b1;
        repeat (4 * (N + 1)) begin
            tick();
            req_addr = req_addr + 24'h000102;
        end
        req_valid = 1'b0;
        while (m_busy) tick();

        // R7 / R3: release while idle in byte organisation
        wide_strap = 1'b0;
        bus_release = 1'b1;
        repeat (2) tick();
        chk("R7 idle release drive", mem_addr_drive, 0);
        bus_release = 1'b0;
        repeat (2) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule